// File: doc/BRIEF.md
# Reference Voltage Slew Limiter

This block drives the digital code of an error-amplifier reference toward a target value. The code never moves faster than a chosen rate. Each step happens on a periodic time-base tick, one pulse per 30 µs window. One code LSB stands for 2 mV, so the fast rate of 200 mV per window is 100 LSB per tick, and the slow rate of 2 mV per window is 1 LSB per tick. The slow rate equals the slowest soft-start rate.

The target has two possible sources. In normal adaptive operation it comes from the voltage bus. In the startup sub-mode it comes from a default-code register. The rate source depends on the phase:

- While soft-start is in progress, the step size comes from the rise-time setting and the slew-select bit has no effect.
- Once soft-start is over, the slew-select bit picks the fast rate or the slow rate.

The last step toward the target is cut short, so the code lands exactly on the target. A change of target while the code is still moving turns the ramp around from where the code is. The code never jumps.

Top module: `vref_slew_limiter`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `vref_code` is 0. `at_target` then reads 1 only if the selected target is 0.
- R2: `vref_code` changes only at a rising clock edge where `tick` is high. With `tick` low it holds, whatever the other inputs do.
- R3: Outside soft-start with `slew_slow` = 0, each tick moves `vref_code` 100 codes toward the target, unless the remaining gap is smaller.
- R4: Outside soft-start with `slew_slow` = 1, each tick moves `vref_code` 1 code toward the target.
- R5: With `ss_active` = 1, each tick moves `vref_code` by `ss_step` codes toward the target, unless the remaining gap is smaller. The value of `slew_slow` has no effect.
- R6: A step never carries `vref_code` past the target. When the gap is smaller than the step, `vref_code` becomes equal to the target.
- R7: `at_target` is 1 exactly when `vref_code` equals the currently selected target.
- R8: With `startup_mode` = 1, the target is `dflt_code`. With `startup_mode` = 0, the target is `bus_code`.
- R9: When the target changes, the next step starts from the present `vref_code`. The step goes in the direction of the new target, downward as well as upward, and is limited by the same step size.
- R10: In soft-start, `ss_step` = 0 holds `vref_code` at its present value even when ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per 30 µs step window |
| startup_mode | input | 1 | 1: target from default register; 0: target from bus |
| bus_code | input | CODE_W | Target code delivered by the voltage bus |
| dflt_code | input | CODE_W | Default-register target code |
| ss_active | input | 1 | Soft-start in progress |
| ss_step | input | SS_W | Codes per tick during soft-start |
| slew_slow | input | 1 | Normal-operation rate select: 0 fast, 1 slow |
| vref_code | output | CODE_W | Present reference code |
| at_target | output | 1 | Reference equals selected target |

## Verification
The bench goes after the clipped final step. A design that adds the full step would overshoot, for example landing on 400 instead of 350. It also reverses the target mid-ramp: a design that reloads the code instead of ramping would jump straight to the new value, and one that keeps its old direction would move away from the target. It also checks that `slew_slow` has no effect during soft-start, that a zero soft-start step holds the code, and that `startup_mode` selects the source. Wrong behaviour shows as a wrong step size or a ramp toward the bus code instead of the default code. Random phases, targets and tick patterns are compared every cycle against a step model computed in the bench.

// File: rtl/vsl_pkg.sv
`timescale 1ns/1ps
package vsl_pkg;

    // where the per-tick step size comes from
    typedef enum logic [1:0] {
        RATE_SOFT = 2'd0,
        RATE_FAST = 2'd1,
        RATE_SLOW = 2'd2
    } rate_src_e;

    // which way the ramp moves on the next tick
    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } ramp_dir_e;

endpackage

// File: rtl/vsl_target_sel.sv
`timescale 1ns/1ps
module vsl_target_sel #(
    parameter int CODE_W = 10
) (
    input  logic              startup_mode,
    input  logic [CODE_W-1:0] bus_code,
    input  logic [CODE_W-1:0] dflt_code,
    output logic [CODE_W-1:0] tgt_code
);

    always_comb begin
        if (startup_mode) begin
            tgt_code = dflt_code;   // startup sub-mode: default register wins
        end else begin
            tgt_code = bus_code;
        end
    end

endmodule

// File: rtl/vsl_rate_sel.sv
`timescale 1ns/1ps
module vsl_rate_sel
    import vsl_pkg::*;
#(
    parameter int CODE_W    = 10,
    parameter int SS_W      = 8,
    parameter int FAST_STEP = 100,
    parameter int SLOW_STEP = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_active,
    input  logic [SS_W-1:0]   ss_step,
    input  logic              slew_slow,
    output logic [CODE_W-1:0] step
);

    localparam logic [CODE_W-1:0] FAST_C = CODE_W'(FAST_STEP);
    localparam logic [CODE_W-1:0] SLOW_C = CODE_W'(SLOW_STEP);

    logic [CODE_W-1:0] ss_ext;
    rate_src_e         src;

    generate
        if (SS_W < CODE_W) begin : g_ss_pad
            assign ss_ext = {{(CODE_W-SS_W){1'b0}}, ss_step};
        end else begin : g_ss_trim
            assign ss_ext = ss_step[CODE_W-1:0];
        end
    endgenerate

    always_comb begin
        if (ss_active) begin
            src = RATE_SOFT;
        end else if (slew_slow) begin
            src = RATE_SLOW;
        end else begin
            src = RATE_FAST;
        end
    end

    always_comb begin
        unique case (src)
            RATE_SOFT: step = ss_ext;
            RATE_SLOW: step = SLOW_C;
            default:   step = FAST_C;
        endcase
    end

    AST_SOFT_FOLLOWS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        ss_active |-> (step == ss_ext)); // R5
    AST_NORMAL_RATE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_active |-> ((slew_slow && step == SLOW_C) || (!slew_slow && step == FAST_C))); // R3

endmodule

// File: rtl/vsl_ramp_core.sv
`timescale 1ns/1ps
module vsl_ramp_core
    import vsl_pkg::*;
#(
    parameter int CODE_W     = 10,
    parameter int RESET_CODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CODE_W-1:0] tgt_code,
    input  logic [CODE_W-1:0] step,
    output logic [CODE_W-1:0] vref_code,
    output logic              at_target
);

    typedef struct packed {
        logic [CODE_W-1:0] vref;
    } ramp_st_t;

    ramp_st_t          st_q, st_d;
    ramp_dir_e         dir;
    logic [CODE_W-1:0] gap;
    logic [CODE_W-1:0] move;

    always_comb begin
        if (tgt_code > st_q.vref) begin
            dir = DIR_UP;
            gap = tgt_code - st_q.vref;
        end else if (tgt_code < st_q.vref) begin
            dir = DIR_DOWN;
            gap = st_q.vref - tgt_code;
        end else begin
            dir = DIR_HOLD;
            gap = '0;
        end
        // final step clipped to the remaining distance
        move = (step < gap) ? step : gap;

        st_d = st_q;
        if (tick) begin
            unique case (dir)
                DIR_UP:   st_d.vref = st_q.vref + move;
                DIR_DOWN: st_d.vref = st_q.vref - move;
                default:  st_d.vref = st_q.vref;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.vref <= CODE_W'(RESET_CODE);
        end else begin
            st_q <= st_d;
        end
    end

    assign vref_code = st_q.vref;
    assign at_target = (dir == DIR_HOLD);

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(vref_code)); // R2
    AST_NO_OVERSHOOT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && tgt_code > vref_code) |=> (vref_code <= $past(tgt_code) && vref_code >= $past(vref_code))); // R6
    AST_NO_OVERSHOOT_DN: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && tgt_code < vref_code) |=> (vref_code >= $past(tgt_code) && vref_code <= $past(vref_code))); // R9
    AST_STEP_BOUND_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && tgt_code > vref_code) |=> ((vref_code - $past(vref_code)) <= $past(step))); // R3
    AST_AT_TARGET_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        at_target |=> $stable(vref_code)); // R7

endmodule

// File: rtl/vref_slew_limiter.sv
`timescale 1ns/1ps
module vref_slew_limiter #(
    parameter int CODE_W     = 10,
    parameter int SS_W       = 8,
    parameter int FAST_STEP  = 100,
    parameter int SLOW_STEP  = 1,
    parameter int RESET_CODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              startup_mode,
    input  logic [CODE_W-1:0] bus_code,
    input  logic [CODE_W-1:0] dflt_code,
    input  logic              ss_active,
    input  logic [SS_W-1:0]   ss_step,
    input  logic              slew_slow,
    output logic [CODE_W-1:0] vref_code,
    output logic              at_target
);

    logic [CODE_W-1:0] tgt_code;
    logic [CODE_W-1:0] step;

    vsl_target_sel #(.CODE_W(CODE_W)) u_tgt (
        .startup_mode (startup_mode),
        .bus_code     (bus_code),
        .dflt_code    (dflt_code),
        .tgt_code     (tgt_code)
    );

    vsl_rate_sel #(
        .CODE_W    (CODE_W),
        .SS_W      (SS_W),
        .FAST_STEP (FAST_STEP),
        .SLOW_STEP (SLOW_STEP)
    ) u_rate (
        .clk       (clk),
        .rst_n     (rst_n),
        .ss_active (ss_active),
        .ss_step   (ss_step),
        .slew_slow (slew_slow),
        .step      (step)
    );

    vsl_ramp_core #(
        .CODE_W     (CODE_W),
        .RESET_CODE (RESET_CODE)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .tgt_code  (tgt_code),
        .step      (step),
        .vref_code (vref_code),
        .at_target (at_target)
    );

    AST_SOURCE_STARTUP: assert property (@(posedge clk) disable iff (!rst_n)
        (startup_mode && at_target) |-> (vref_code == dflt_code)); // R8

endmodule

// File: tb/vref_slew_limiter_test.sv
`timescale 1ns/1ps
module vref_slew_limiter_test;

    localparam int CODE_W = 10;
    localparam int SS_W   = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              tick;
    logic              startup_mode;
    logic [CODE_W-1:0] bus_code;
    logic [CODE_W-1:0] dflt_code;
    logic              ss_active;
    logic [SS_W-1:0]   ss_step;
    logic              slew_slow;
    logic [CODE_W-1:0] vref_code;
    logic              at_target;

    always #5 clk = ~clk;

    vref_slew_limiter uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .startup_mode (startup_mode),
        .bus_code     (bus_code),
        .dflt_code    (dflt_code),
        .ss_active    (ss_active),
        .ss_step      (ss_step),
        .slew_slow    (slew_slow),
        .vref_code    (vref_code),
        .at_target    (at_target)
    );

    int vectors     = 0;
    int miscompares = 0;
    int m_vref      = 0;
    bit finished    = 0;

    function automatic int f_target(input bit st, input int bus, input int dflt);
        return st ? dflt : bus;
    endfunction

    function automatic int f_step(input bit ss, input int sst, input bit slow);
        if (ss) return sst;
        return slow ? 1 : 100;
    endfunction

    function automatic int f_next(input int v, input int t, input int s);
        if (t > v) return (t - v < s) ? t : v + s;
        if (t < v) return (v - t < s) ? t : v - s;
        return v;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // called at a negedge; applies one clock edge and checks at the next negedge
    task automatic cyc(input bit tk, input bit st, input int bus, input int dflt,
                       input bit ss, input int sst, input bit slow, input string req);
        int t;
        tick = tk; startup_mode = st; bus_code = CODE_W'(bus); dflt_code = CODE_W'(dflt);
        ss_active = ss; ss_step = SS_W'(sst); slew_slow = slow;
        t = f_target(st, bus, dflt);
        if (tk) m_vref = f_next(m_vref, t, f_step(ss, sst, slow));
        @(negedge clk);
        check(req, int'(vref_code), m_vref);
        check("R7", int'(at_target), (m_vref == t) ? 1 : 0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end

    initial begin
        rst_n = 1'b0; tick = 1'b1; startup_mode = 1'b0; bus_code = 10'd300;
        dflt_code = 10'd0; ss_active = 1'b0; ss_step = '0; slew_slow = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", int'(vref_code), 0);
        check("R1", int'(at_target), 0);
        bus_code = 10'd0;
        #1;
        check("R1", int'(at_target), 1);
        rst_n = 1'b1;
        m_vref = 0;

        // R2: no tick, no motion
        for (int i = 0; i < 4; i++) cyc(0, 0, 350, 0, 0, 0, 0, "R2");
        // R3 fast ramp then R6 clipped final step
        cyc(1, 0, 350, 0, 0, 0, 0, "R3");
        cyc(1, 0, 350, 0, 0, 0, 0, "R3");
        cyc(1, 0, 350, 0, 0, 0, 0, "R3");
        cyc(1, 0, 350, 0, 0, 0, 0, "R6");
        check("R6", int'(vref_code), 350);
        cyc(1, 0, 350, 0, 0, 0, 0, "R7");
        // R4 slow descent
        for (int i = 0; i < 5; i++) cyc(1, 0, 340, 0, 0, 0, 1, "R4");
        check("R4", int'(vref_code), 345);
        // R5 soft-start step, slew bit ignored
        cyc(1, 0, 500, 0, 1, 7, 1, "R5");
        check("R5", int'(vref_code), 352);
        cyc(1, 0, 500, 0, 1, 7, 0, "R5");
        // R10 zero soft-start step holds
        for (int i = 0; i < 3; i++) cyc(1, 0, 500, 0, 1, 0, 0, "R10");
        check("R10", int'(vref_code), 359);
        // R8 startup mode uses default register
        cyc(1, 1, 100, 600, 0, 0, 0, "R8");
        check("R8", int'(vref_code), 459);
        // R9 redirect mid-ramp, no jump
        cyc(1, 0, 420, 600, 0, 0, 0, "R9");
        check("R9", int'(vref_code), 420);
        cyc(1, 1, 0, 700, 0, 0, 0, "R9");
        cyc(1, 0, 5, 700, 0, 0, 0, "R9");
        check("R9", int'(vref_code), 420);
        cyc(1, 0, 5, 700, 0, 0, 1, "R9");
        check("R9", int'(vref_code), 419);

        // constrained random
        begin
            int bus, dflt, sst, seed_dummy;
            bit st, ss, slow, tk;
            string req;
            seed_dummy = int'($urandom(32'd20240611));
            bus = 512; dflt = 128; sst = 4; st = 0; ss = 0; slow = 0;
            for (int n = 0; n < 4000; n++) begin
                if ($urandom_range(0, 9) == 0) bus  = int'($urandom_range(0, 1023));
                if ($urandom_range(0, 19) == 0) dflt = int'($urandom_range(0, 1023));
                if ($urandom_range(0, 15) == 0) st   = ($urandom_range(0, 4) == 0);
                if ($urandom_range(0, 15) == 0) ss   = ($urandom_range(0, 4) == 0);
                if ($urandom_range(0, 15) == 0) slow = $urandom_range(0, 1) == 1;
                if ($urandom_range(0, 7) == 0)  sst  = int'($urandom_range(0, 40));
                tk = ($urandom_range(0, 1) == 1);
                if (!tk)       req = "R2";
                else if (st)   req = "R8";
                else if (ss)   req = (sst == 0) ? "R10" : "R5";
                else if (slow) req = "R4";
                else           req = "R3";
                cyc(tk, st, bus, dflt, ss, sst, slow, req);
            end
        end

        finished = 1;
        summary();
    end

endmodule